// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides when a small 8-bit CPU subsystem enters and leaves its three low-power modes. Software asks for a mode through a two-bit power-control register or through a separate suspend bit. Once the instruction that made the request has completed, the block halts the CPU. Depending on the mode, it also gates the peripheral clocks and stops the internal oscillator. The CPU core, the oscillator, the watchdog counter and the interrupt controller stay outside the block. They reach it only through strobes and request lines.

Each mode has its own way out:

- **Idle** keeps the peripherals clocked. Any enabled interrupt or any reset ends it, and an interrupt exit clears the idle bit.
- **Stop** turns off every clock the block controls. Only a reset ends it.
- **Suspend** also stops the oscillator. Three peripheral events can end it: a port mismatch, the comparator output going low, or a timer overflow. Each event is seen without a clock and turns the oscillator back on at once. The CPU is released only after a fixed settle count, and the suspend bit is cleared at the same time.

Top module: `pwr_mode_seq`

## Requirements
- R1: After rst_n is released the block is in Run. In Run, mode_stat is 00, cpu_halt is 0, periph_clk_en is 1, int_osc_en is 1, pcon_bits is 00, susp_bit is 0 and cpu_restart is 0.
- R2: A mode request takes effect only at a clock edge where instr_done is high. At that edge the request bit must be either already held or being written in the same cycle. Until then mode_stat stays 00 and cpu_halt stays 0.
- R3: In pcon_bits, bit 0 requests Idle and bit 1 requests Stop. susp_bit requests Suspend. When several requests are present, Stop wins over Suspend and Suspend wins over Idle. mode_stat encodes the mode as 00 Run, 01 Idle, 10 Stop and 11 Suspend.
- R4: In Idle, cpu_halt is 1, periph_clk_en is 1 and int_osc_en is 1.
- R5: In Idle, irq_pend high at an edge returns the block to Run at that edge and clears bit 0 of pcon_bits.
- R6: The reset request is ext_rst_req, or wdt_rst_req while wdt_en is 1. It returns any mode to Run at the next edge and clears pcon_bits and susp_bit. It also raises cpu_restart for exactly one cycle, which tells the core to restart at address 0x0000. wdt_rst_req has no effect while wdt_en is 0.
- R7: In Stop, cpu_halt is 1, periph_clk_en is 0 and int_osc_en is 0. In Stop, irq_pend and the three wake events have no effect.
- R8: In Suspend, cpu_halt is 1 and periph_clk_en is 0. int_osc_en is 0 until a wake event appears: port_mismatch high, cmp_out low, or t3_ovf high. int_osc_en then goes to 1 in the same cycle, with no clock edge needed.
- R9: The first edge that sees a wake event in Suspend starts the settle period. The block returns to Run exactly SETTLE_CYCLES edges after that edge, and clears susp_bit at the same time. Throughout the settle period mode_stat stays 11 and cpu_halt and int_osc_en stay 1.
- R10: irq_pend has no effect in Suspend. irq_pend and the wake events have no effect in Run.
- R11: Writes to pcon_bits and susp_bit are ignored while the block is not in Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcon_we | input | 1 | Write strobe for the power-control bits |
| pcon_wdata | input | 2 | Power-control write data (bit 0 Idle, bit 1 Stop) |
| susp_we | input | 1 | Write strobe for the suspend bit |
| susp_wdata | input | 1 | Suspend bit write data |
| instr_done | input | 1 | The current instruction completes in this cycle |
| irq_pend | input | 1 | An enabled interrupt is asserted |
| ext_rst_req | input | 1 | External or internal reset request |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_rst_req | input | 1 | Watchdog reset request |
| port_mismatch | input | 1 | Port-mismatch wake event |
| cmp_out | input | 1 | Comparator output; low is a wake event |
| t3_ovf | input | 1 | Timer overflow wake event |
| cpu_halt | output | 1 | Gates the CPU clock off |
| periph_clk_en | output | 1 | Peripheral clock enable |
| int_osc_en | output | 1 | Internal oscillator enable |
| cpu_restart | output | 1 | One-cycle pulse: restart the core at address 0x0000 |
| mode_stat | output | 2 | Mode code: 00 Run, 01 Idle, 10 Stop, 11 Suspend |
| pcon_bits | output | 2 | Current power-control bits |
| susp_bit | output | 1 | Current suspend bit |

## Verification
The bench builds the block with the default SETTLE_CYCLES of 16. This lets it count the settle period edge by edge and check the first edge at which the CPU is released.

It sweeps all eight combinations of the two power-control bits and the suspend bit. Each combination is tried twice: once with the completion strobe in the same cycle as the write, and once a cycle later. This covers every priority case and both entry timings. Each mode is then left through its own exit, and the bench also tries the stimuli that exit must ignore. Suspend wakes rotate across the three wake sources.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_STOP   = 3'd2,
    ST_SUSP   = 3'd3,
    ST_SETTLE = 3'd4
  } pwr_state_e;

  localparam int unsigned IDLE_BIT = 0;
  localparam int unsigned STOP_BIT = 1;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_IDLE = 2'b01;
  localparam logic [1:0] MODE_STOP = 2'b10;
  localparam logic [1:0] MODE_SUSP = 2'b11;

  function automatic logic [1:0] mode_code(input pwr_state_e s);
    case (s)
      ST_IDLE:            mode_code = MODE_IDLE;
      ST_STOP:            mode_code = MODE_STOP;
      ST_SUSP, ST_SETTLE: mode_code = MODE_SUSP;
      default:            mode_code = MODE_RUN;
    endcase
  endfunction

endpackage

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pcon_we,
  input  logic [1:0] pcon_wdata,
  input  logic       susp_we,
  input  logic       susp_wdata,
  input  logic       wr_ok,
  input  logic       clr_all,
  input  logic       clr_idle,
  input  logic       clr_susp,
  output logic [1:0] pcon_q,
  output logic       susp_q,
  output logic       eff_idle,
  output logic       eff_stop,
  output logic       eff_susp
);

  logic       pcon_wr;
  logic       susp_wr;
  logic [1:0] pcon_eff;
  logic [1:0] pcon_d;
  logic       susp_d;

  assign pcon_wr  = pcon_we & wr_ok;
  assign susp_wr  = susp_we & wr_ok;
  assign pcon_eff = pcon_wr ? pcon_wdata : pcon_q;

  // A request written in the completing cycle already counts
  assign eff_idle = pcon_eff[IDLE_BIT];
  assign eff_stop = pcon_eff[STOP_BIT];
  assign eff_susp = susp_wr ? susp_wdata : susp_q;

  always_comb begin
    pcon_d = pcon_q;
    susp_d = susp_q;
    if (clr_all) begin
      pcon_d = '0;
      susp_d = 1'b0;
    end else begin
      if (pcon_wr)       pcon_d = pcon_wdata;
      else if (clr_idle) pcon_d[IDLE_BIT] = 1'b0;
      if (susp_wr)       susp_d = susp_wdata;
      else if (clr_susp) susp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcon_q <= '0;
      susp_q <= 1'b0;
    end else begin
      pcon_q <= pcon_d;
      susp_q <= susp_d;
    end
  end

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);

  localparam int unsigned CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = start | active;
  assign done   = active & (cnt_q == LAST);

  always_comb begin
    if (start) cnt_d = '0;
    else       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_done,
  input  logic       eff_idle,
  input  logic       eff_stop,
  input  logic       eff_susp,
  input  logic       irq_pend,
  input  logic       rst_any,
  input  logic       wake_any,
  input  logic       settle_done,
  output pwr_state_e state_q,
  output logic       settle_start
);

  pwr_state_e state_d;

  always_comb begin
    state_d      = state_q;
    settle_start = 1'b0;
    if (rst_any) begin
      state_d = ST_RUN;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (instr_done) begin
            if (eff_stop)      state_d = ST_STOP;
            else if (eff_susp) state_d = ST_SUSP;
            else if (eff_idle) state_d = ST_IDLE;
          end
        end
        ST_IDLE:   if (irq_pend) state_d = ST_RUN;
        ST_STOP:   state_d = ST_STOP;
        ST_SUSP: begin
          if (wake_any) begin
            state_d      = ST_SETTLE;
            settle_start = 1'b1;
          end
        end
        ST_SETTLE: if (settle_done) state_d = ST_RUN;
        default:   state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pcon_we,
  input  logic [1:0] pcon_wdata,
  input  logic       susp_we,
  input  logic       susp_wdata,
  input  logic       instr_done,
  input  logic       irq_pend,
  input  logic       ext_rst_req,
  input  logic       wdt_en,
  input  logic       wdt_rst_req,
  input  logic       port_mismatch,
  input  logic       cmp_out,
  input  logic       t3_ovf,
  output logic       cpu_halt,
  output logic       periph_clk_en,
  output logic       int_osc_en,
  output logic       cpu_restart,
  output logic [1:0] mode_stat,
  output logic [1:0] pcon_bits,
  output logic       susp_bit
);

  pwr_state_e state;
  logic rst_any, wake_any;
  logic eff_idle, eff_stop, eff_susp;
  logic settle_start, settle_done;
  logic restart_q;

  assign rst_any  = ext_rst_req | (wdt_en & wdt_rst_req);
  // Wake detection is purely combinational: no clock runs in Suspend
  assign wake_any = port_mismatch | ~cmp_out | t3_ovf;

  pwr_ctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .pcon_we    (pcon_we),
    .pcon_wdata (pcon_wdata),
    .susp_we    (susp_we),
    .susp_wdata (susp_wdata),
    .wr_ok      (state == ST_RUN),
    .clr_all    (rst_any),
    .clr_idle   ((state == ST_IDLE) & irq_pend),
    .clr_susp   (settle_done),
    .pcon_q     (pcon_bits),
    .susp_q     (susp_bit),
    .eff_idle   (eff_idle),
    .eff_stop   (eff_stop),
    .eff_susp   (eff_susp)
  );

  pwr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (settle_start),
    .active (state == ST_SETTLE),
    .done   (settle_done)
  );

  pwr_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_done   (instr_done),
    .eff_idle     (eff_idle),
    .eff_stop     (eff_stop),
    .eff_susp     (eff_susp),
    .irq_pend     (irq_pend),
    .rst_any      (rst_any),
    .wake_any     (wake_any),
    .settle_done  (settle_done),
    .state_q      (state),
    .settle_start (settle_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_q <= 1'b0;
    else        restart_q <= rst_any;
  end

  assign cpu_restart   = restart_q;
  assign cpu_halt      = (state != ST_RUN);
  assign periph_clk_en = (state == ST_RUN) | (state == ST_IDLE);
  assign int_osc_en    = (state == ST_RUN) | (state == ST_IDLE) | (state == ST_SETTLE)
                       | ((state == ST_SUSP) & wake_any);
  assign mode_stat     = mode_code(state);

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_done,
  input logic       irq_pend,
  input logic       ext_rst_req,
  input logic       wdt_en,
  input logic       wdt_rst_req,
  input logic       port_mismatch,
  input logic       cmp_out,
  input logic       t3_ovf,
  input logic       cpu_halt,
  input logic       periph_clk_en,
  input logic       int_osc_en,
  input logic       cpu_restart,
  input logic [1:0] mode_stat,
  input logic [1:0] pcon_bits
);

  logic rst_req;
  logic wake_ev;
  assign rst_req = ext_rst_req | (wdt_en & wdt_rst_req);
  assign wake_ev = port_mismatch | ~cmp_out | t3_ovf;

  p_no_entry_without_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b00 && !instr_done) |=> (mode_stat == 2'b00 && !cpu_halt));

  p_idle_clocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b01) |-> (cpu_halt && periph_clk_en && int_osc_en));

  p_idle_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b01 && irq_pend && !rst_req) |=> (mode_stat == 2'b00 && !pcon_bits[0]));

  p_reset_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (mode_stat == 2'b00 && cpu_restart && pcon_bits == 2'b00));

  p_stop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b10 && !rst_req) |=> (mode_stat == 2'b10));

  p_stop_clocks_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b10) |-> (!int_osc_en && !periph_clk_en && cpu_halt));

  p_susp_wake_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b11 && wake_ev) |-> int_osc_en);

  p_susp_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b11) |-> (cpu_halt && !periph_clk_en));

  p_stop_bit_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat != 2'b00 && !rst_req) |=> (pcon_bits[1] == $past(pcon_bits[1])));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_done    (instr_done),
  .irq_pend      (irq_pend),
  .ext_rst_req   (ext_rst_req),
  .wdt_en        (wdt_en),
  .wdt_rst_req   (wdt_rst_req),
  .port_mismatch (port_mismatch),
  .cmp_out       (cmp_out),
  .t3_ovf        (t3_ovf),
  .cpu_halt      (cpu_halt),
  .periph_clk_en (periph_clk_en),
  .int_osc_en    (int_osc_en),
  .cpu_restart   (cpu_restart),
  .mode_stat     (mode_stat),
  .pcon_bits     (pcon_bits)
);

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;

  localparam int unsigned SETTLE = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic pcon_we, susp_we, susp_wdata, instr_done, irq_pend;
  logic [1:0] pcon_wdata;
  logic ext_rst_req, wdt_en, wdt_rst_req, port_mismatch, cmp_out, t3_ovf;
  logic cpu_halt, periph_clk_en, int_osc_en, cpu_restart, susp_bit;
  logic [1:0] mode_stat, pcon_bits;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwr_mode_seq #(.SETTLE_CYCLES(SETTLE)) u_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
    .susp_we(susp_we), .susp_wdata(susp_wdata), .instr_done(instr_done),
    .irq_pend(irq_pend), .ext_rst_req(ext_rst_req), .wdt_en(wdt_en),
    .wdt_rst_req(wdt_rst_req), .port_mismatch(port_mismatch), .cmp_out(cmp_out),
    .t3_ovf(t3_ovf), .cpu_halt(cpu_halt), .periph_clk_en(periph_clk_en),
    .int_osc_en(int_osc_en), .cpu_restart(cpu_restart), .mode_stat(mode_stat),
    .pcon_bits(pcon_bits), .susp_bit(susp_bit)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic quiet;
    pcon_we = 0; pcon_wdata = 0; susp_we = 0; susp_wdata = 0; instr_done = 0;
    irq_pend = 0; ext_rst_req = 0; wdt_rst_req = 0;
    port_mismatch = 0; cmp_out = 1; t3_ovf = 0;
  endtask

  task automatic do_reset_req;
    ext_rst_req = 1; tick; ext_rst_req = 0;
    chk("R6", "restart pulse", cpu_restart, 1);
    chk("R6", "mode after reset", mode_stat, 0);
    chk("R6", "pcon cleared", pcon_bits, 0);
    chk("R6", "susp cleared", susp_bit, 0);
    tick;
    chk("R6", "restart one cycle", cpu_restart, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    quiet();
    wdt_en = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick;
    chk("R1", "mode", mode_stat, 0);
    chk("R1", "halt", cpu_halt, 0);
    chk("R1", "periph", periph_clk_en, 1);
    chk("R1", "osc", int_osc_en, 1);
    chk("R1", "pcon", pcon_bits, 0);
    chk("R1", "susp", susp_bit, 0);
    chk("R1", "restart", cpu_restart, 0);

    for (int t = 0; t < 2; t++) begin
      for (int v = 0; v < 8; v++) begin
        int exp_mode;
        int w;
        exp_mode = v[1] ? 2 : (v[2] ? 3 : (v[0] ? 1 : 0));
        w = (v + t) % 3;
        pcon_we = 1; pcon_wdata = v[1:0]; susp_we = 1; susp_wdata = v[2];
        instr_done = (t == 1);
        tick;
        pcon_we = 0; susp_we = 0; instr_done = 0;
        if (t == 0) begin
          chk("R2", "no entry before completion", mode_stat, 0);
          chk("R2", "no halt before completion", cpu_halt, 0);
          chk("R2", "pcon written", pcon_bits, v[1:0]);
          instr_done = 1; tick; instr_done = 0;
        end
        chk("R3", "mode after entry", mode_stat, exp_mode);
        chk("R4", "halt", cpu_halt, exp_mode != 0);
        chk("R7", "periph clk", periph_clk_en, exp_mode < 2);
        chk("R8", "osc", int_osc_en, exp_mode < 2);
        case (exp_mode)
          0: begin
            irq_pend = 1; port_mismatch = 1; t3_ovf = 1; tick; quiet();
            chk("R10", "run ignores irq/wake", mode_stat, 0);
          end
          1: begin
            chk("R4", "idle bit held", pcon_bits, v[1:0]);
            irq_pend = 1; tick; irq_pend = 0;
            chk("R5", "idle exit mode", mode_stat, 0);
            chk("R5", "idle bit cleared", pcon_bits[0], 0);
            chk("R5", "halt released", cpu_halt, 0);
          end
          2: begin
            irq_pend = 1; t3_ovf = 1; cmp_out = 0; port_mismatch = 1;
            pcon_we = 1; pcon_wdata = 0;
            tick; quiet();
            chk("R7", "stop ignores irq/wake", mode_stat, 2);
            chk("R11", "write ignored in stop", pcon_bits, v[1:0]);
          end
          default: begin
            irq_pend = 1; tick; irq_pend = 0;
            chk("R10", "suspend ignores irq", mode_stat, 3);
            chk("R8", "osc off before wake", int_osc_en, 0);
            if (w == 0) port_mismatch = 1;
            else if (w == 1) cmp_out = 0;
            else t3_ovf = 1;
            #1;
            chk("R8", "osc on without edge", int_osc_en, 1);
            tick; quiet();
            for (int k = 1; k < SETTLE; k++) tick;
            chk("R9", "still settling mode", mode_stat, 3);
            chk("R9", "still halted", cpu_halt, 1);
            chk("R9", "osc during settle", int_osc_en, 1);
            chk("R9", "susp kept while settling", susp_bit, 1);
            tick;
            chk("R9", "released after settle", cpu_halt, 0);
            chk("R9", "run after settle", mode_stat, 0);
            chk("R9", "susp cleared", susp_bit, 0);
          end
        endcase
        do_reset_req();
      end
    end

    // Watchdog request gated by its enable
    pcon_we = 1; pcon_wdata = 2'b01; instr_done = 1; tick; quiet();
    chk("R4", "idle entered", mode_stat, 1);
    wdt_en = 0; wdt_rst_req = 1; tick;
    chk("R6", "disabled watchdog ignored", mode_stat, 1);
    chk("R6", "no restart when disabled", cpu_restart, 0);
    wdt_en = 1; tick; wdt_rst_req = 0; wdt_en = 0;
    chk("R6", "watchdog ends idle", mode_stat, 0);
    chk("R6", "watchdog restart", cpu_restart, 1);
    tick;

    // Writes ignored in suspend, then reset during settle
    susp_we = 1; susp_wdata = 1; instr_done = 1; tick; quiet();
    chk("R3", "suspend entered", mode_stat, 3);
    pcon_we = 1; pcon_wdata = 2'b10; susp_we = 1; susp_wdata = 0; tick; quiet();
    chk("R11", "pcon write ignored in suspend", pcon_bits, 0);
    chk("R11", "susp write ignored in suspend", susp_bit, 1);
    t3_ovf = 1; tick; t3_ovf = 0;
    repeat (3) tick;
    chk("R9", "settling", mode_stat, 3);
    do_reset_req();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule